// File: doc/BRIEF.md
# Priority-Threshold Interrupt Controller

This block gathers up to 32 interrupt lines and turns them into a single request toward a processor. Each line carries its own enable bit, its own trigger type (level or edge) and its own 3-bit priority. A global threshold hides lines whose priority is too low. Among the lines that remain, a fixed arbiter picks the highest priority and reports its number and priority next to the request.

Software drives the block through a small word-wide register port with a write strobe, a 3-bit address, write data and combinational read data. Enable bits are changed through separate set and clear words, so one line can be touched without a read-modify-write. Each priority is written with a line index and a value in the same word. Latched edge events are cleared by writing a mask of ones.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all enable bits, type bits, priorities, edge latches and the threshold are zero, `irq_req` is 0, and every readable register reads 0.
- R2: A write to address 0 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R3: A write to address 1 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: `reg_rdata` shows the enable mask at address 2, the type mask at address 3 (bit n = 1 means line n is edge type, 0 means level), and the threshold in bits [2:0] at address 5. Every other address reads 0.
- R5: A level-type line is pending in the cycle after its source is sampled high and stops being pending in the cycle after its source is sampled low. No software clear is needed.
- R6: An edge-type line latches a rising edge, which is a sample of 1 after a sample of 0. It stays pending after the source falls, until a write to address 6 with its bit set clears the latch.
- R7: If a rising edge arrives in the same cycle as a clear of that line's latch, the latch stays set.
- R8: A write to address 4 sets the priority of the line given in data bits [12:8] to the value in data bits [2:0].
- R9: A write to address 5 sets the threshold from data bits [2:0]. A line whose priority is below the threshold cannot request. A line with priority 0 never requests.
- R10: `irq_req` is 1 exactly when some line is pending, enabled and passes the threshold. `irq_id` and `irq_prio` name the eligible line with the highest priority, and the lowest line number wins a tie.
- R11: Edge latches capture events while a line is disabled. Enabling the line later raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 32 | Interrupt sources, one bit per line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_id | output | 5 | Number of the winning line |
| irq_prio | output | 3 | Priority of the winning line |

## Verification
The bench goes after a clear that lands in the same cycle as a new edge. A design that gives the clear precedence would lose that event. It also checks ties between equal priorities: an arbiter that scans the wrong way reports the highest line number instead of the lowest. Lines at priority 0 and lines exactly at the threshold are probed, because an off-by-one compare either leaks a masked line or hides one that should pass. Edges that arrive while a line is disabled are checked too: a design that gates the latch with the enable bit would drop the event when the line is enabled later.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic [2:0] {
      A_EN_SET   = 3'd0,
      A_EN_CLR   = 3'd1,
      A_EN_RD    = 3'd2,
      A_TYPE     = 3'd3,
      A_PRIO     = 3'd4,
      A_THR      = 3'd5,
      A_EDGE_CLR = 3'd6
   } reg_addr_e;

   localparam int ADDR_W       = 3;
   localparam int PRIO_IDX_LSB = 8;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import prio_irq_pkg::*;
#(
   parameter int N_LINES = 32,
   parameter int PRIO_W  = 3,
   parameter int DATA_W  = 32,
   parameter int ID_W    = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic [N_LINES-1:0]        en,
   output logic [N_LINES-1:0]        edge_type,
   output logic [N_LINES*PRIO_W-1:0] prio_flat,
   output logic [PRIO_W-1:0]         thr,
   output logic [N_LINES-1:0]        edge_clr
);
   logic [PRIO_W-1:0] prio_q [N_LINES];
   logic [ID_W-1:0]   widx;

   assign widx     = wdata[PRIO_IDX_LSB +: ID_W];
   assign edge_clr = (we && addr == A_EDGE_CLR) ? wdata[N_LINES-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en        <= '0;
         edge_type <= '0;
         thr       <= '0;
      end else if (we) begin
         case (addr)
            A_EN_SET: en        <= en | wdata[N_LINES-1:0];
            A_EN_CLR: en        <= en & ~wdata[N_LINES-1:0];
            A_TYPE:   edge_type <= wdata[N_LINES-1:0];
            A_THR:    thr       <= wdata[PRIO_W-1:0];
            default:  ;
         endcase
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_prio
      always_ff @(posedge clk) begin
         if (!rst_n)
            prio_q[i] <= '0;
         else if (we && addr == A_PRIO && widx == ID_W'(i))
            prio_q[i] <= wdata[PRIO_W-1:0];
      end
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_EN_RD: rdata[N_LINES-1:0] = en;
         A_TYPE:  rdata[N_LINES-1:0] = edge_type;
         A_THR:   rdata[PRIO_W-1:0]  = thr;
         default: rdata = '0;
      endcase
   end

   a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_EN_SET) |=> ((en & $past(wdata[N_LINES-1:0])) == $past(wdata[N_LINES-1:0])));
   a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_EN_CLR) |=> ((en & $past(wdata[N_LINES-1:0])) == '0));
   a_r9_thr_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_THR) |=> (thr == $past(wdata[PRIO_W-1:0])));
endmodule

// File: rtl/irq_line_pend.sv
module irq_line_pend #(
   parameter int N_LINES = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] src,
   input  logic [N_LINES-1:0] edge_type,
   input  logic [N_LINES-1:0] clr,
   output logic [N_LINES-1:0] pending
);
   logic [N_LINES-1:0] src_q;
   logic [N_LINES-1:0] lat_q;
   logic [N_LINES-1:0] rise;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign rise[i] = edge_type[i] & src[i] & ~src_q[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_q[i] <= 1'b0;
            lat_q[i] <= 1'b0;
         end else begin
            src_q[i] <= src[i];
            lat_q[i] <= (lat_q[i] & ~clr[i]) | rise[i];
         end
      end

      assign pending[i] = edge_type[i] ? lat_q[i] : src_q[i];

      a_r6_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_type[i] && src[i] && !src_q[i]) |=> lat_q[i]);
      a_r6_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !(edge_type[i] && src[i] && !src_q[i])) |=> !lat_q[i]);
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N_LINES = 32,
   parameter int PRIO_W  = 3,
   parameter int ID_W    = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_LINES-1:0]        pending,
   input  logic [N_LINES-1:0]        en,
   input  logic [N_LINES*PRIO_W-1:0] prio_flat,
   input  logic [PRIO_W-1:0]         thr,
   output logic                      req,
   output logic [ID_W-1:0]           id,
   output logic [PRIO_W-1:0]         prio
);
   always_comb begin
      logic [PRIO_W-1:0] p;
      prio = '0;
      id   = '0;
      for (int i = 0; i < N_LINES; i++) begin
         p = prio_flat[i*PRIO_W +: PRIO_W];
         if (pending[i] && en[i] && p != '0 && p >= thr && p > prio) begin
            prio = p;
            id   = ID_W'(i);
         end
      end
      req = (prio != '0);
   end

   a_r10_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (pending[id] && en[id] && prio >= thr && prio != '0));
   a_r9_no_req_above_all: assert property (@(posedge clk) disable iff (!rst_n)
      (pending == '0) |-> !req);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int N_LINES = 32,
   parameter int PRIO_W  = 3,
   parameter int DATA_W  = 32,
   localparam int ID_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_src,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_req,
   output logic [ID_W-1:0]    irq_id,
   output logic [PRIO_W-1:0]  irq_prio
);
   if (N_LINES < 1 || N_LINES > DATA_W) begin : g_bad_lines
      $error("N_LINES must be 1..DATA_W");
   end
   if (PRIO_W < 1 || PRIO_IDX_LSB + ID_W > DATA_W || PRIO_W > PRIO_IDX_LSB) begin : g_bad_prio
      $error("priority field does not fit the write word");
   end

   logic [N_LINES-1:0]        en;
   logic [N_LINES-1:0]        edge_type;
   logic [N_LINES*PRIO_W-1:0] prio_flat;
   logic [PRIO_W-1:0]         thr;
   logic [N_LINES-1:0]        edge_clr;
   logic [N_LINES-1:0]        pending;

   irq_cfg_regs #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .en(en), .edge_type(edge_type), .prio_flat(prio_flat),
      .thr(thr), .edge_clr(edge_clr)
   );

   irq_line_pend #(.N_LINES(N_LINES)) u_lines (
      .clk(clk), .rst_n(rst_n), .src(irq_src), .edge_type(edge_type),
      .clr(edge_clr), .pending(pending)
   );

   irq_pick #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .pending(pending), .en(en), .prio_flat(prio_flat),
      .thr(thr), .req(irq_req), .id(irq_id), .prio(irq_prio)
   );

   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !irq_req);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] irq_src;
   logic        reg_we;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        irq_req;
   logic [4:0]  irq_id;
   logic [2:0]  irq_prio;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   logic [31:0] m_en, m_ty, m_lat, m_sq;
   logic [2:0]  m_pr [32];
   logic [2:0]  m_thr;

   always #4 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio)
   );

   function automatic logic [31:0] exp_rdata(input logic [2:0] a);
      case (a)
         3'd2:    return m_en;
         3'd3:    return m_ty;
         3'd5:    return {29'd0, m_thr};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [8:0] exp_irq();
      logic [2:0]  bp = 3'd0;
      logic [4:0]  bi = 5'd0;
      logic [31:0] pend = (m_ty & m_lat) | (~m_ty & m_sq);
      for (int i = 0; i < 32; i++)
         if (pend[i] && m_en[i] && m_pr[i] != 0 && m_pr[i] >= m_thr && m_pr[i] > bp) begin
            bp = m_pr[i];
            bi = 5'(i);
         end
      return {(bp != 0), bi, bp};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      m_en = 0; m_ty = 0; m_lat = 0; m_sq = 0; m_thr = 0;
      for (int i = 0; i < 32; i++) m_pr[i] = 0;
   endtask

   task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] s, input string tag);
      logic [31:0] rise;
      logic [31:0] clr;
      logic [8:0]  e;
      reg_we = we; reg_addr = a; reg_wdata = d; irq_src = s;
      @(posedge clk);
      rise  = s & ~m_sq & m_ty;
      clr   = (we && a == 3'd6) ? d : 32'd0;
      m_lat = (m_lat & ~clr) | rise;
      m_sq  = s;
      if (we) case (a)
         3'd0: m_en  = m_en | d;
         3'd1: m_en  = m_en & ~d;
         3'd3: m_ty  = d;
         3'd4: m_pr[d[12:8]] = d[2:0];
         3'd5: m_thr = d[2:0];
         default: ;
      endcase
      #2;
      e = exp_irq();
      check(tag, {23'd0, irq_req, irq_id, irq_prio}, {23'd0, e});
      check({tag, " rdata"}, reg_rdata, exp_rdata(a));
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; irq_src = 0;
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1: reset state
      check("R1 req", {31'd0, irq_req}, 32'd0);
      step(0, 3'd2, 0, 0, "R1 en");
      step(0, 3'd3, 0, 0, "R1 type");
      step(0, 3'd5, 0, 0, "R1 thr");
      // R2 / R3 / R4
      step(1, 3'd0, 32'h0000_00F0, 0, "R2 set");
      step(1, 3'd0, 32'h0000_0003, 0, "R2 set more");
      step(0, 3'd2, 0, 0, "R4 read en F3");
      check("R2 value", reg_rdata, 32'h0000_00F3);
      step(1, 3'd1, 32'h0000_0030, 0, "R3 clr");
      step(0, 3'd2, 0, 0, "R4 read en C3");
      check("R3 value", reg_rdata, 32'h0000_00C3);
      step(0, 3'd7, 0, 0, "R4 unused addr");
      // R8 / R5: level line 5 priority 3
      step(1, 3'd4, (32'd5 << 8) | 3, 0, "R8 prio5");
      step(1, 3'd0, 32'h20, 0, "R2 en5");
      step(0, 3'd2, 0, 32'h20, "R5 level high");
      check("R5 id", {27'd0, irq_id}, 32'd5);
      step(0, 3'd2, 0, 0, "R5 level low");
      check("R5 drop", {31'd0, irq_req}, 32'd0);
      // R6: edge line 7 priority 4
      step(1, 3'd3, 32'h80, 0, "R4 type");
      step(1, 3'd4, (32'd7 << 8) | 4, 0, "R8 prio7");
      step(1, 3'd0, 32'h80, 0, "R2 en7");
      step(0, 3'd2, 0, 32'h80, "R6 rise");
      step(0, 3'd2, 0, 0, "R6 hold");
      step(0, 3'd2, 0, 0, "R6 hold2");
      check("R6 held id", {27'd0, irq_id}, 32'd7);
      step(1, 3'd6, 32'h80, 0, "R6 clear");
      check("R6 cleared", {31'd0, irq_req}, 32'd0);
      // R7: rise in same cycle as clear
      step(0, 3'd2, 0, 32'h80, "R7 set");
      step(0, 3'd2, 0, 0, "R7 low");
      step(1, 3'd6, 32'h80, 32'h80, "R7 clr+rise");
      check("R7 kept", {31'd0, irq_req}, 32'd1);
      // R9: threshold
      step(1, 3'd5, 5, 32'h80, "R9 thr5 masks");
      check("R9 masked", {31'd0, irq_req}, 32'd0);
      step(1, 3'd5, 4, 32'h80, "R9 thr4 equal passes");
      check("R9 equal", {31'd0, irq_req}, 32'd1);
      step(1, 3'd5, 0, 32'h80, "R9 thr0");
      step(1, 3'd4, (32'd7 << 8) | 0, 32'h80, "R9 prio0 never");
      check("R9 prio0", {31'd0, irq_req}, 32'd0);
      step(1, 3'd6, 32'h80, 0, "R6 clear7");
      // R10: tie between lines 2 and 9 at priority 6
      step(1, 3'd4, (32'd2 << 8) | 6, 0, "R8 prio2");
      step(1, 3'd4, (32'd9 << 8) | 6, 0, "R8 prio9");
      step(1, 3'd0, 32'h204, 0, "R2 en2 en9");
      step(0, 3'd2, 0, 32'h224, "R10 tie");
      check("R10 tie id", {27'd0, irq_id}, 32'd2);
      step(0, 3'd2, 0, 32'h220, "R10 line9");
      step(0, 3'd2, 0, 0, "R10 idle");
      // R11: edge while disabled
      step(1, 3'd4, (32'd12 << 8) | 7, 0, "R8 prio12");
      step(1, 3'd3, 32'h1080, 0, "R4 type12");
      step(0, 3'd2, 0, 32'h1000, "R11 event disabled");
      check("R11 no req", {31'd0, irq_req}, 32'd0);
      step(1, 3'd0, 32'h1000, 0, "R11 enable");
      check("R11 id", {27'd0, irq_id}, 32'd12);
      step(1, 3'd6, 32'hFFFF_FFFF, 0, "R6 clear all");
      // Random phase
      void'($urandom(32'd1234));
      s = 0;
      for (int n = 0; n < 4000; n++) begin
         logic        w;
         logic [2:0]  a;
         logic [31:0] d;
         for (int b = 0; b < 32; b++)
            if ($urandom_range(7) == 0) s[b] = ~s[b];
         w = ($urandom_range(9) < 3);
         a = 3'($urandom_range(7));
         d = $urandom;
         if (a == 3'd4) d = {19'd0, 5'($urandom_range(31)), 5'd0, 3'($urandom_range(7))};
         if (a == 3'd5) d = {29'd0, 3'($urandom_range(7))};
         step(w, a, d, s, "R10 random");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule